// File: doc/BRIEF.md
# Digital PLL Lock Detector

This block judges whether a phase-locked loop has settled. It watches the output pulses of the reference divider and the feedback divider. In every phase-detector cycle it measures the time between the two rising edges, counted in ticks of a fast sampling clock. Both divider signals are asynchronous to that clock, so each one passes through a synchroniser before edge detection.

The lock flag sets only after a run of consecutive cycles with small phase error. The run is three cycles in coarse mode and five in fine mode, chosen by a precision input. Once set, the flag holds until one cycle shows an error above a larger unlock threshold. Errors that fall between the two thresholds keep an existing lock, but they do not count towards a new one. If one edge arrives and its partner does not follow within a timeout, the cycle counts as a large error. All thresholds are parameters in sampling ticks. The defaults assume a 400 MHz sampling clock: 6 ticks is about 15 ns and 10 ticks is about 25 ns.

Top module: `pll_lock_detect`

## Requirements
- R1: After reset the lock output `lock_o` is 0 and the consecutive-cycle run is empty.
- R2: With `precise_i`=0, `lock_o` goes to 1 after three consecutive cycles whose error is below LOCK_TICKS (default 6). Two such cycles leave it at 0.
- R3: With `precise_i`=1, five consecutive qualifying cycles are needed. Four leave `lock_o` at 0.
- R4: While locked, one cycle with error greater than UNLOCK_TICKS (default 10) clears `lock_o`. An error of exactly UNLOCK_TICKS does not.
- R5: While locked, cycles with error from LOCK_TICKS up to UNLOCK_TICKS inclusive leave `lock_o` at 1.
- R6: While unlocked, a cycle with error at or above LOCK_TICKS empties the run, so counting starts again from zero.
- R7: The error is the number of sampling ticks between the first and the second divider edge, whichever divider leads. Equal edges give an error of 0.
- R8: If the partner edge has not arrived TIMEOUT_TICKS (default 40) ticks after the leading edge, the cycle is treated as exceeding the unlock threshold.
- R9: After lock is lost, regaining it needs a complete new run of qualifying cycles.
- R10: `lock_o` changes only in the cycle that follows a completed measurement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sampling clock; one tick is one period |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ref_div_i | input | 1 | Reference divider output pulse, asynchronous |
| fb_div_i | input | 1 | Feedback divider output pulse, asynchronous |
| precise_i | input | 1 | 0: three-cycle run, 1: five-cycle run |
| lock_o | output | 1 | Lock flag, active high |

## Verification
The hardest state to reach from the ports is a run that is cleared before it completes. This happens when a mid-band error arrives partway through a run, while the block is still unlocked. It must not break anything visible, yet it must still empty the hidden count. The stimulus gives two good cycles, then one cycle with an error of exactly LOCK_TICKS, then two more good cycles. The bench expects no lock at that point. A single further good cycle must then set the flag, which shows that the count restarted from zero. The timeout path is reached by pulsing only one divider and holding it past the timeout. This is done with each divider leading in turn.

// File: rtl/pll_ld_pkg.sv
package pll_ld_pkg;

    // Which divider edge opened the current measurement window.
    typedef enum logic [1:0] {
        MS_IDLE      = 2'd0,
        MS_REF_FIRST = 2'd1,
        MS_FB_FIRST  = 2'd2
    } meter_st_e;

    // Classification of one completed phase-detector cycle.
    typedef enum logic [1:0] {
        V_GOOD    = 2'd0,
        V_NEUTRAL = 2'd1,
        V_BAD     = 2'd2
    } verdict_e;

endpackage

// File: rtl/ld_edge_sync.sv
module ld_edge_sync #(
    parameter int CHANNELS = 2,
    parameter int STAGES   = 2
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic [CHANNELS-1:0] async_i,
    output logic [CHANNELS-1:0] rise_o
);
    for (genvar c = 0; c < CHANNELS; c++) begin : g_ch
        typedef struct packed {
            logic [STAGES-1:0] chain;
            logic              prev;
        } sync_t;

        sync_t s_d, s_q;

        always_comb begin
            s_d       = s_q;
            s_d.chain = {s_q.chain[STAGES-2:0], async_i[c]};
            s_d.prev  = s_q.chain[STAGES-1];
        end

        always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) s_q <= '0;
            else         s_q <= s_d;
        end

        assign rise_o[c] = s_q.chain[STAGES-1] & ~s_q.prev;
    end
endmodule

// File: rtl/ld_phase_meter.sv
module ld_phase_meter
    import pll_ld_pkg::*;
#(
    parameter int TIMEOUT_TICKS = 40,
    localparam int ERR_W = $clog2(TIMEOUT_TICKS + 1)
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             ref_rise_i,
    input  logic             fb_rise_i,
    output logic             valid_o,
    output logic             tout_o,
    output logic [ERR_W-1:0] err_o
);
    localparam logic [ERR_W-1:0] TOUT = ERR_W'(TIMEOUT_TICKS);

    typedef struct packed {
        meter_st_e        st;
        logic [ERR_W-1:0] gap;
        logic             valid;
        logic             tout;
        logic [ERR_W-1:0] err;
    } meter_t;

    meter_t m_d, m_q;
    logic   partner;

    always_comb begin
        m_d       = m_q;
        m_d.valid = 1'b0;
        m_d.tout  = 1'b0;
        partner   = (m_q.st == MS_REF_FIRST) ? fb_rise_i : ref_rise_i;
        unique case (m_q.st)
            MS_IDLE: begin
                if (ref_rise_i && fb_rise_i) begin
                    m_d.valid = 1'b1;
                    m_d.err   = '0;
                end else if (ref_rise_i) begin
                    m_d.st  = MS_REF_FIRST;
                    m_d.gap = ERR_W'(1);
                end else if (fb_rise_i) begin
                    m_d.st  = MS_FB_FIRST;
                    m_d.gap = ERR_W'(1);
                end
            end
            MS_REF_FIRST, MS_FB_FIRST: begin
                if (partner) begin
                    m_d.valid = 1'b1;
                    m_d.err   = m_q.gap;
                    m_d.st    = MS_IDLE;
                end else if (m_q.gap == TOUT) begin
                    m_d.valid = 1'b1;
                    m_d.tout  = 1'b1;
                    m_d.err   = m_q.gap;
                    m_d.st    = MS_IDLE;
                end else begin
                    m_d.gap = m_q.gap + ERR_W'(1);
                end
            end
            default: m_d.st = MS_IDLE;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) m_q <= '{st: MS_IDLE, default: '0};
        else         m_q <= m_d;
    end

    assign valid_o = m_q.valid;
    assign tout_o  = m_q.tout;
    assign err_o   = m_q.err;
endmodule

// File: rtl/ld_lock_judge.sv
module ld_lock_judge
    import pll_ld_pkg::*;
#(
    parameter int ERR_W        = 6,
    parameter int LOCK_TICKS   = 6,
    parameter int UNLOCK_TICKS = 10,
    parameter int RUN_COARSE   = 3,
    parameter int RUN_FINE     = 5,
    localparam int RUN_MAX = (RUN_FINE > RUN_COARSE) ? RUN_FINE : RUN_COARSE,
    localparam int RUN_W   = $clog2(RUN_MAX + 1)
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             valid_i,
    input  logic             tout_i,
    input  logic [ERR_W-1:0] err_i,
    input  logic             precise_i,
    output logic             lock_o
);
    localparam logic [ERR_W-1:0] LOCK_T   = ERR_W'(LOCK_TICKS);
    localparam logic [ERR_W-1:0] UNLOCK_T = ERR_W'(UNLOCK_TICKS);
    localparam logic [RUN_W-1:0] NEED_LO  = RUN_W'(RUN_COARSE);
    localparam logic [RUN_W-1:0] NEED_HI  = RUN_W'(RUN_FINE);

    typedef struct packed {
        logic             locked;
        logic [RUN_W-1:0] run;
    } judge_t;

    judge_t           j_d, j_q;
    verdict_e         verdict;
    logic [RUN_W-1:0] need;
    logic [RUN_W-1:0] run_inc;

    always_comb begin
        if (tout_i || err_i > UNLOCK_T) verdict = V_BAD;
        else if (err_i < LOCK_T)        verdict = V_GOOD;
        else                            verdict = V_NEUTRAL;
        need    = precise_i ? NEED_HI : NEED_LO;
        run_inc = j_q.run + RUN_W'(1);

        j_d = j_q;
        if (valid_i) begin
            unique case (verdict)
                V_BAD: begin
                    j_d.locked = 1'b0;
                    j_d.run    = '0;
                end
                V_GOOD: begin
                    if (!j_q.locked) begin
                        if (run_inc >= need) begin
                            j_d.locked = 1'b1;
                            j_d.run    = '0;
                        end else begin
                            j_d.run = run_inc;
                        end
                    end
                end
                default: begin
                    if (!j_q.locked) j_d.run = '0;
                end
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) j_q <= '0;
        else         j_q <= j_d;
    end

    assign lock_o = j_q.locked;
endmodule

// File: rtl/pll_lock_detect.sv
module pll_lock_detect #(
    parameter int LOCK_TICKS    = 6,
    parameter int UNLOCK_TICKS  = 10,
    parameter int TIMEOUT_TICKS = 40,
    parameter int RUN_COARSE    = 3,
    parameter int RUN_FINE      = 5,
    parameter int SYNC_STAGES   = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic ref_div_i,
    input  logic fb_div_i,
    input  logic precise_i,
    output logic lock_o
);
    localparam int ERR_W = $clog2(TIMEOUT_TICKS + 1);

    logic [1:0]       rise;
    logic             meas_valid;
    logic             meas_tout;
    logic [ERR_W-1:0] meas_err;

    ld_edge_sync #(
        .CHANNELS(2),
        .STAGES  (SYNC_STAGES)
    ) u_sync (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .async_i({fb_div_i, ref_div_i}),
        .rise_o (rise)
    );

    ld_phase_meter #(
        .TIMEOUT_TICKS(TIMEOUT_TICKS)
    ) u_meter (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .ref_rise_i(rise[0]),
        .fb_rise_i (rise[1]),
        .valid_o   (meas_valid),
        .tout_o    (meas_tout),
        .err_o     (meas_err)
    );

    ld_lock_judge #(
        .ERR_W       (ERR_W),
        .LOCK_TICKS  (LOCK_TICKS),
        .UNLOCK_TICKS(UNLOCK_TICKS),
        .RUN_COARSE  (RUN_COARSE),
        .RUN_FINE    (RUN_FINE)
    ) u_judge (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .valid_i  (meas_valid),
        .tout_i   (meas_tout),
        .err_i    (meas_err),
        .precise_i(precise_i),
        .lock_o   (lock_o)
    );
endmodule

// File: rtl/pll_lock_detect_chk.sv
module pll_lock_detect_chk #(
    parameter int ERR_W        = 6,
    parameter int LOCK_TICKS   = 6,
    parameter int UNLOCK_TICKS = 10
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             meas_valid,
    input logic             meas_tout,
    input logic [ERR_W-1:0] meas_err,
    input logic             lock_o
);
    localparam logic [ERR_W-1:0] LOCK_T   = ERR_W'(LOCK_TICKS);
    localparam logic [ERR_W-1:0] UNLOCK_T = ERR_W'(UNLOCK_TICKS);

    // R10: lock moves only right after a measurement completes
    a_r10_idle_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !meas_valid |=> $stable(lock_o));

    // R4 / R8: large or missing-edge cycle drops lock
    a_r4_big_err_unlocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (meas_valid && (meas_tout || meas_err > UNLOCK_T)) |=> !lock_o);

    // R5: mid-band error keeps an existing lock
    a_r5_mid_keeps_lock: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (meas_valid && lock_o && !meas_tout && meas_err >= LOCK_T
         && meas_err <= UNLOCK_T) |=> lock_o);

    // R6: mid-band error cannot create lock
    a_r6_mid_no_lock: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (meas_valid && !lock_o && !meas_tout && meas_err >= LOCK_T) |=> !lock_o);

    // R2 / R3: a rise of lock follows a small-error measurement
    a_r2_rise_after_good: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(lock_o) |-> ($past(meas_valid) && !$past(meas_tout)
                           && $past(meas_err) < LOCK_T));
endmodule

bind pll_lock_detect pll_lock_detect_chk #(
    .ERR_W       (ERR_W),
    .LOCK_TICKS  (LOCK_TICKS),
    .UNLOCK_TICKS(UNLOCK_TICKS)
) u_chk (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .meas_valid(meas_valid),
    .meas_tout (meas_tout),
    .meas_err  (meas_err),
    .lock_o    (lock_o)
);

// File: tb/tb_pll_lock_detect.sv
module tb_pll_lock_detect;
    localparam int CLK_PERIOD = 10;
    localparam int TOUT       = 40;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ref_div = 1'b0;
    logic fb_div = 1'b0;
    logic precise = 1'b0;
    logic lock;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    pll_lock_detect dut (
        .clk_i    (clk),
        .rst_ni   (rst_n),
        .ref_div_i(ref_div),
        .fb_div_i (fb_div),
        .precise_i(precise),
        .lock_o   (lock)
    );

    task automatic chk(input logic act, input logic exp, input string req);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: lock actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic do_reset(input logic prec);
        @(negedge clk);
        rst_n   = 1'b0;
        ref_div = 1'b0;
        fb_div  = 1'b0;
        precise = prec;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    // One phase-detector cycle with the given error in ticks.
    task automatic pd(input int gap, input bit fb_first);
        @(negedge clk);
        if (fb_first) fb_div = 1'b1; else ref_div = 1'b1;
        repeat (gap) @(negedge clk);
        ref_div = 1'b1;
        fb_div  = 1'b1;
        repeat (2) @(negedge clk);
        ref_div = 1'b0;
        fb_div  = 1'b0;
        repeat (8) @(negedge clk);
    endtask

    // One cycle in which only the leading divider fires.
    task automatic lone(input bit fb_first);
        @(negedge clk);
        if (fb_first) fb_div = 1'b1; else ref_div = 1'b1;
        repeat (TOUT + 8) @(negedge clk);
        ref_div = 1'b0;
        fb_div  = 1'b0;
        repeat (8) @(negedge clk);
    endtask

    task automatic t_reset();
        do_reset(1'b0);
        chk(lock, 1'b0, "R1 after reset");
    endtask

    task automatic t_coarse();
        do_reset(1'b0);
        pd(0, 0); pd(5, 0);
        chk(lock, 1'b0, "R2 two good cycles");
        pd(3, 0);
        chk(lock, 1'b1, "R2 third good cycle");
    endtask

    task automatic t_fine();
        do_reset(1'b1);
        for (int i = 0; i < 4; i++) pd(i, 0);
        chk(lock, 1'b0, "R3 four good cycles");
        pd(5, 0);
        chk(lock, 1'b1, "R3 fifth good cycle");
    endtask

    task automatic t_hold_and_break();
        do_reset(1'b0);
        repeat (3) pd(1, 0);
        pd(6, 0);
        chk(lock, 1'b1, "R5 error at lock threshold");
        pd(8, 1);
        chk(lock, 1'b1, "R5 mid error");
        pd(10, 0);
        chk(lock, 1'b1, "R4 error equal to unlock threshold");
        pd(11, 0);
        chk(lock, 1'b0, "R4 error above unlock threshold");
    endtask

    task automatic t_run_cleared();
        do_reset(1'b0);
        pd(2, 0); pd(2, 0);
        pd(6, 0);
        pd(2, 0); pd(2, 0);
        chk(lock, 1'b0, "R6 run emptied by mid error");
        pd(2, 0);
        chk(lock, 1'b1, "R6 lock after fresh full run");
    endtask

    task automatic t_fb_leads();
        do_reset(1'b0);
        repeat (3) pd(5, 1);
        chk(lock, 1'b1, "R7 lock with feedback leading");
        pd(11, 1);
        chk(lock, 1'b0, "R7 large error with feedback leading");
    endtask

    task automatic t_timeout();
        do_reset(1'b0);
        repeat (3) pd(0, 0);
        chk(lock, 1'b1, "R8 locked before missing edge");
        lone(0);
        chk(lock, 1'b0, "R8 reference-only cycle unlocks");
        repeat (3) pd(0, 0);
        lone(1);
        chk(lock, 1'b0, "R8 feedback-only cycle unlocks");
    endtask

    task automatic t_relock();
        do_reset(1'b0);
        pd(1, 0); pd(1, 0);
        pd(20, 0);
        pd(1, 0); pd(1, 0);
        chk(lock, 1'b0, "R9 partial run before relock");
        repeat (3) pd(1, 0);
        pd(15, 1);
        pd(1, 0); pd(1, 0);
        chk(lock, 1'b0, "R9 two good after unlock");
        pd(1, 0);
        chk(lock, 1'b1, "R9 relock after full run");
        repeat (40) @(negedge clk);
        chk(lock, 1'b1, "R10 lock steady without measurements");
    endtask

    initial begin
        t_reset();
        t_coarse();
        t_fine();
        t_hold_and_break();
        t_run_cleared();
        t_fb_leads();
        t_timeout();
        t_relock();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule